// File: doc/BRIEF.md
# MSI Doorbell Write Decoder

This block sits behind a fixed address window that PCI functions write to when they signal a message interrupt. It splits each write address into two fields. The upper field picks a device slot, with each slot taking a 64 KiB stride of the window. The lower 16 bits, shifted right by two, form a vector index. That index is ORed with the write data, so two encodings work through the same path: one where the vector sits in the address, and one where it sits in the low data bits. The vector is added to the base interrupt number stored for the slot. The result selects one interrupt line, which receives a single-cycle pulse.

The allocator fills a small slot table through a plain load port. Each entry holds a base number and an allocated flag. A write is dropped if it targets a slot beyond the table, a slot that is not allocated, or a line beyond the last interrupt line. Reads of the window have no defined meaning. The block acknowledges them with zero data and does nothing else.

Top module: `msidb_doorbell`

## Requirements
- R1: After reset, `irq_pulse` is all zero and every table entry is unallocated, so a doorbell write made before any table load raises no line.
- R2: `wr_ready` and `rd_ready` are low while `rst` is high and high in every cycle after it. The block never stalls a write or a read.
- R3: For an accepted write, the slot index is `wr_addr[ADDR_W-1:16]`. The line number is base[slot] + vector, and it pulses in the cycle right after the handshake cycle.
- R4: The vector is `wr_addr[15:2]` ORed bitwise with `wr_data`. Address bits 1:0 have no effect.
- R5: A pulse lasts one cycle unless another accepted write selects the same line, and at most one bit of `irq_pulse` is high in any cycle.
- R6: A write whose slot index is NUM_SLOTS or more raises no line.
- R7: A write to a slot whose allocated flag is clear raises no line.
- R8: A write whose base + vector is IRQ_CNT or more raises no line. The sum is formed without truncation.
- R9: A load with `tbl_we` high stores `tbl_base` and `tbl_alloc` into entry `tbl_slot`, and a cleared `tbl_alloc` frees the entry. A doorbell write in the same cycle still sees the old entry, and the new entry applies from the next cycle.
- R10: An accepted read raises `rsp_valid` for exactly the next cycle with `rsp_data` zero, and raises no line.
- R11: Writes accepted in consecutive cycles each give their own pulse, in consecutive cycles. No line pulses in a cycle that does not follow an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Doorbell write request |
| wr_ready | output | 1 | Write accepted when both valid and ready are high |
| wr_addr | input | ADDR_W | Byte offset within the doorbell window |
| wr_data | input | DATA_W | Write data, byte 0 in bits 7:0 |
| rd_valid | input | 1 | Read request to the window |
| rd_ready | output | 1 | Read accepted when both valid and ready are high |
| rsp_valid | output | 1 | Read completion, one cycle after acceptance |
| rsp_data | output | DATA_W | Read completion data, always zero |
| tbl_we | input | 1 | Slot table load strobe |
| tbl_slot | input | SLOT_IW | Slot table entry to load |
| tbl_base | input | IRQ_W | Base interrupt number to store |
| tbl_alloc | input | 1 | Allocated flag to store |
| irq_pulse | output | IRQ_CNT | One-hot interrupt pulses |

## Verification
The bench sweeps every slot field value, including those beyond the table depth, across many address and data vector patterns with the low address bits varied. A design that truncated the slot field would alias high slots onto real ones and pulse lines that should stay quiet. A design that used a plus in place of the OR, or kept address bits 1:0 in the vector, would pulse the wrong line. The sum is driven exactly to the last line and one past it, and once with all data bits set. These cases catch a truncated adder, which would wrap around and fire a low line. A table load and a write to the same slot in the same cycle, a freed slot, back-to-back writes and reads are each checked. These catch bypass of the load path, stale allocation flags, lost or merged pulses, and reads that trigger interrupts.

// File: rtl/msidb_pkg.sv
package msidb_pkg;
  // log2 of the byte stride that each device slot covers in the window
  localparam int unsigned SLOT_STRIDE_LG = 16;
  // byte offset bits below the address-encoded vector index
  localparam int unsigned VEC_SHIFT = 2;
endpackage

// File: rtl/msidb_slot_table.sv
module msidb_slot_table #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned IRQ_W     = 8,
  localparam int unsigned SLOT_IW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_we,
  input  logic [SLOT_IW-1:0] ld_slot,
  input  logic [IRQ_W-1:0]   ld_base,
  input  logic               ld_alloc,
  input  logic [SLOT_IW-1:0] rd_slot,
  output logic [IRQ_W-1:0]   rd_base,
  output logic               rd_alloc
);
  logic [IRQ_W-1:0] base_q  [NUM_SLOTS];
  logic             alloc_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g]  <= '0;
        alloc_q[g] <= 1'b0;
      end else if (ld_we && (32'(ld_slot) == g)) begin
        base_q[g]  <= ld_base;
        alloc_q[g] <= ld_alloc;
      end
    end
  end

  always_comb begin
    rd_base  = '0;
    rd_alloc = 1'b0;
    if (32'(rd_slot) < NUM_SLOTS) begin
      rd_base  = base_q[rd_slot];
      rd_alloc = alloc_q[rd_slot];
    end
  end
endmodule

// File: rtl/msidb_decode.sv
module msidb_decode
  import msidb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IRQ_CNT   = 256,
  localparam int unsigned IRQ_W    = $clog2(IRQ_CNT),
  localparam int unsigned SLOT_IW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned SLOT_FW  = ADDR_W - SLOT_STRIDE_LG,
  localparam int unsigned SUM_W    = DATA_W + 1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic [SLOT_IW-1:0] slot_idx,
  output logic               slot_in_range,
  input  logic [IRQ_W-1:0]   slot_base,
  input  logic               slot_alloc,
  output logic               hit,
  output logic [IRQ_W-1:0]   line
);
  logic [SLOT_FW-1:0]        slot_field;
  logic [SLOT_STRIDE_LG-1:0] addr_vec;
  logic [DATA_W-1:0]         vector;
  logic [SUM_W-1:0]          sum;

  always_comb begin
    slot_field    = addr[ADDR_W-1:SLOT_STRIDE_LG];
    slot_idx      = slot_field[SLOT_IW-1:0];
    slot_in_range = 32'(slot_field) < NUM_SLOTS;
    addr_vec      = addr[SLOT_STRIDE_LG-1:0] >> VEC_SHIFT;
    vector        = DATA_W'(addr_vec) | data;
    sum           = {1'b0, vector} + SUM_W'(slot_base);
    hit           = slot_in_range && slot_alloc && (sum < SUM_W'(IRQ_CNT));
    line          = sum[IRQ_W-1:0];
  end
endmodule

// File: rtl/msidb_pulse.sv
module msidb_pulse #(
  parameter int unsigned IRQ_CNT = 256,
  localparam int unsigned IRQ_W  = $clog2(IRQ_CNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [IRQ_W-1:0]   line,
  output logic [IRQ_CNT-1:0] pulse
);
  for (genvar g = 0; g < IRQ_CNT; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) pulse[g] <= 1'b0;
      else     pulse[g] <= fire && (32'(line) == g);
    end
  end
endmodule

// File: rtl/msidb_doorbell.sv
module msidb_doorbell
  import msidb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IRQ_CNT   = 256,
  localparam int unsigned IRQ_W    = $clog2(IRQ_CNT),
  localparam int unsigned SLOT_IW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_valid,
  output logic               rd_ready,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic               tbl_we,
  input  logic [SLOT_IW-1:0] tbl_slot,
  input  logic [IRQ_W-1:0]   tbl_base,
  input  logic               tbl_alloc,
  output logic [IRQ_CNT-1:0] irq_pulse
);
  logic [SLOT_IW-1:0] dec_slot;
  logic               dec_in_range;
  logic [IRQ_W-1:0]   ent_base;
  logic               ent_alloc;
  logic               dec_hit;
  logic [IRQ_W-1:0]   dec_line;
  logic               wr_fire;

  assign wr_ready = !rst;
  assign rd_ready = !rst;
  assign rsp_data = '0;

  msidb_slot_table #(.NUM_SLOTS(NUM_SLOTS), .IRQ_W(IRQ_W)) u_table (
    .clk(clk), .rst(rst),
    .ld_we(tbl_we), .ld_slot(tbl_slot), .ld_base(tbl_base), .ld_alloc(tbl_alloc),
    .rd_slot(dec_slot), .rd_base(ent_base), .rd_alloc(ent_alloc)
  );

  msidb_decode #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .IRQ_CNT(IRQ_CNT)) u_decode (
    .addr(wr_addr), .data(wr_data),
    .slot_idx(dec_slot), .slot_in_range(dec_in_range),
    .slot_base(ent_base), .slot_alloc(ent_alloc),
    .hit(dec_hit), .line(dec_line)
  );

  assign wr_fire = wr_valid && wr_ready && dec_hit;

  msidb_pulse #(.IRQ_CNT(IRQ_CNT)) u_pulse (
    .clk(clk), .rst(rst), .fire(wr_fire), .line(dec_line), .pulse(irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= rd_valid && rd_ready;
  end
endmodule

// File: rtl/msidb_doorbell_chk.sv
module msidb_doorbell_chk #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned IRQ_CNT   = 256
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic               rsp_valid,
  input logic [IRQ_CNT-1:0] irq_pulse
);
  a_r5_one_line: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_pulse));

  a_r11_pulse_needs_write: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_ready) |=> (irq_pulse == '0));

  a_r6_out_of_table: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && (32'(wr_addr[ADDR_W-1:16]) >= NUM_SLOTS))
      |=> (irq_pulse == '0));

  a_r10_read_completes: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready) |=> rsp_valid);

  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_ready) |=> !rsp_valid);

  a_r2_ready_out_of_reset: assert property (@(posedge clk) disable iff (rst)
    wr_ready && rd_ready);
endmodule

bind msidb_doorbell msidb_doorbell_chk #(
  .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .IRQ_CNT(IRQ_CNT)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rsp_valid(rsp_valid), .irq_pulse(irq_pulse)
);

// File: tb/test_msidb_doorbell.sv
`timescale 1ns/1ps
module test_msidb_doorbell;
  localparam int NS = 4;
  localparam int AW = 19;
  localparam int DW = 32;
  localparam int IC = 64;
  localparam int IW = 6;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          tbl_we = 1'b0;
  logic [SW-1:0] tbl_slot = '0;
  logic [IW-1:0] tbl_base = '0;
  logic          tbl_alloc = 1'b0;
  logic [IC-1:0] irq_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  int m_base [NS];
  bit m_alloc [NS];

  always #5 clk = ~clk;

  msidb_doorbell #(.NUM_SLOTS(NS), .ADDR_W(AW), .DATA_W(DW), .IRQ_CNT(IC)) i_msidb_doorbell (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tbl_we(tbl_we), .tbl_slot(tbl_slot),
    .tbl_base(tbl_base), .tbl_alloc(tbl_alloc), .irq_pulse(irq_pulse)
  );

  task automatic check(string req, logic [IC-1:0] act, logic [IC-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [IC-1:0] expect_line(int slot, logic [15:0] off, logic [DW-1:0] d);
    longint v;
    longint s;
    if (slot >= NS) return '0;
    if (!m_alloc[slot]) return '0;
    v = longint'(off >> 2) | longint'(d);
    s = v + m_base[slot];
    if (s >= IC) return '0;
    return IC'(1) << s;
  endfunction

  task automatic load(int slot, int base, bit alloc);
    @(negedge clk);
    tbl_we = 1'b1; tbl_slot = SW'(slot); tbl_base = IW'(base); tbl_alloc = alloc;
    @(negedge clk);
    tbl_we = 1'b0;
    m_base[slot] = base; m_alloc[slot] = alloc;
  endtask

  task automatic doorbell(string req, int slot, logic [15:0] off, logic [DW-1:0] d);
    logic [IC-1:0] e;
    e = expect_line(slot, off, d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = {3'(slot), off}; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check(req, irq_pulse, e);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin m_base[i] = 0; m_alloc[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1 pulse in reset", irq_pulse, '0);
    check("R2 ready low in reset", IC'({wr_ready, rd_ready}), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 ready after reset", IC'({wr_ready, rd_ready}), IC'(3));
    // R1: nothing allocated yet
    doorbell("R1 unallocated after reset", 0, 16'h0004, 32'h0);

    load(0, 0, 1'b1);
    load(1, 10, 1'b1);
    load(2, 40, 1'b1);

    // R3 R4 R6 R7 sweep: slot field, address vector with low bits, data vector
    for (int s = 0; s < 8; s++)
      for (int idx = 0; idx < 16; idx++)
        for (int k = 0; k < 4; k++)
          for (int dsel = 0; dsel < 4; dsel++) begin
            logic [DW-1:0] d;
            d = (dsel == 0) ? 32'd0 : (dsel == 1) ? 32'd1 : (dsel == 2) ? 32'd6 : 32'd16;
            doorbell((s >= NS) ? "R6 slot beyond table" : (s == 3) ? "R7 unallocated slot" : "R3 R4 line select",
                     s, 16'(idx * 4 + k), d);
          end

    // R8 boundary: 40 + 23 = 63 is last line, 40 + 24 is past it
    doorbell("R8 last line", 2, 16'(23 * 4), 32'h0);
    doorbell("R8 one past last", 2, 16'h0, 32'd24);
    doorbell("R8 large address vector", 0, 16'hFFFC, 32'h0);
    doorbell("R8 all data bits", 1, 16'h0, 32'hFFFF_FFFF);

    // R5: pulse gone one cycle after a single write
    doorbell("R5 pulse", 1, 16'h0008, 32'h0);
    @(negedge clk);
    check("R5 pulse ends", irq_pulse, '0);

    // R9: load and write to slot 3 in the same cycle; old (free) entry applies
    @(negedge clk);
    tbl_we = 1'b1; tbl_slot = 2'd3; tbl_base = 6'd20; tbl_alloc = 1'b1;
    wr_valid = 1'b1; wr_addr = {3'd3, 16'h0004}; wr_data = 32'h0;
    @(negedge clk);
    tbl_we = 1'b0; wr_valid = 1'b0;
    check("R9 same-cycle load not seen", irq_pulse, '0);
    m_base[3] = 20; m_alloc[3] = 1'b1;
    doorbell("R9 new entry applies", 3, 16'h0004, 32'h2);
    load(3, 20, 1'b0);
    doorbell("R9 freed entry", 3, 16'h0004, 32'h0);

    // R11: back-to-back writes give consecutive pulses
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = {3'd1, 16'h0000}; wr_data = 32'd3;
    @(negedge clk);
    wr_addr = {3'd2, 16'h0000}; wr_data = 32'd5;
    check("R11 first pulse", irq_pulse, IC'(1) << 13);
    @(negedge clk);
    wr_valid = 1'b0;
    check("R11 second pulse", irq_pulse, IC'(1) << 45);
    @(negedge clk);
    check("R11 idle after burst", irq_pulse, '0);

    // R10: read completes one cycle later with zero data and no interrupt
    @(negedge clk);
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R10 rsp_valid", IC'(rsp_valid), IC'(1));
    check("R10 rsp_data", IC'(rsp_data), '0);
    check("R10 read raises no line", irq_pulse, '0);
    @(negedge clk);
    check("R10 rsp one cycle", IC'(rsp_valid), '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule